// File: doc/BRIEF.md
# Dual-Sided Mailbox with Per-Byte Interrupts

This block is a shared byte mailbox that links a host processor to a management controller. Each side has its own register port with address, write strobe, read strobe, write data and registered read data. Both ports see the same bank of data bytes. A write by one side to a data byte sets a sticky status bit for that byte in the other side's status bank. Each status bit has its own interrupt enable, so the receiving side can treat one chosen byte as a targeted interrupt source.

Next to the per-byte path, each side has a control register. It holds a sticky interrupt flag, a mask for that flag and a self-clearing doorbell bit. The host's flag is set by any management write to a data byte and by a management doorbell. The management side's flag is set by a host doorbell. Each side gets one interrupt line. The line is high when an enabled status bit is set, or when the side's flag is set and not masked.

The address map follows from `NUM_BYTES`. Data bytes come first. Then come the status banks (eight bytes per bank), the management control byte, the host control byte, the management enable banks and the host enable banks. With the default of 16 bytes the offsets are as listed below.

Top module: `mbx_dual_irq`

## Requirements
- R1: After reset every data, status, enable and control register reads 0x00 from both ports, and both interrupt outputs are low.
- R2: Data bytes at offsets 0x00 to 0x0F can be written and read from either port, and a read returns the last value written. If both ports write the same byte in the same cycle, the management value is stored.
- R3: A management write to data byte N sets bit N%8 of the host status byte at offset 0x10 (N<8) or 0x11 (N>=8). A host write to byte N sets the same bit in the management status bank at the same offsets. No other event sets a status bit.
- R4: Status bits are write-one-to-clear. A 1 in the write data clears that bit, and a 0 leaves it unchanged.
- R5: If a set event and a write-one-to-clear reach the same status bit or control flag in the same cycle, the bit stays set.
- R6: Each interrupt output goes high while any status bit of its side is set together with its enable. Management enables are at 0x14/0x15 and host enables at 0x16/0x17, with bit positions matching the status bytes. The other side's enables have no effect.
- R7: Any management write to a data byte sets bit 7 of the host control byte (0x13). That flag drives the host interrupt only while bit 1 (mask) of the same byte is 0. Writing 1 to bit 7 clears the flag.
- R8: Writing bit 0 (doorbell) of the host control byte sets bit 7 of the management control byte (0x12) and raises the management interrupt. A management doorbell at 0x12 sets the host flag. The doorbell bit always reads 0. Writing 0x03 both masks and rings in one write.
- R9: A side's writes to the other side's control byte or enable banks are ignored. Neither the readback nor the interrupts change.
- R10: The read data is updated on the clock edge that samples the read strobe, and it holds its value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | ADDR_W | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| h_irq | output | 1 | Interrupt to the host |
| m_addr | input | ADDR_W | Management register address |
| m_wr | input | 1 | Management write strobe |
| m_rd | input | 1 | Management read strobe |
| m_wdata | input | 8 | Management write data |
| m_rdata | output | 8 | Management read data, registered |
| m_irq | output | 1 | Interrupt to the management side |

## Verification
The bench puts a status set and a write-one-to-clear on the same bit in one cycle, and does the same with a data write and a flag clear. A design that let the clear win would lose that event, and the bit would read back 0. Both ports write one data byte in the same cycle: with the wrong priority the host value survives, or a status bank fails to record the write. The bench also checks that the doorbell reads back as 0, and that a combined mask-and-ring write both masks and rings. Writes to the other side's control byte and enable banks are checked for no effect; a loose address decode would change the readback or raise an interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int BYTE_W        = 8;
   localparam int CTRL_FLAG_BIT = 7;
   localparam int CTRL_MASK_BIT = 1;
   localparam int CTRL_RING_BIT = 0;

   // Read view of a control byte: the doorbell bit never reads back.
   function automatic logic [BYTE_W-1:0] ctrl_view(input logic flag, input logic mask);
      logic [BYTE_W-1:0] v;
      v                = '0;
      v[CTRL_FLAG_BIT] = flag;
      v[CTRL_MASK_BIT] = mask;
      return v;
   endfunction
endpackage

// File: rtl/mbx_data_bank.sv
module mbx_data_bank #(
   parameter int NUM_BYTES = 16,
   parameter int ADDR_W    = 5,
   parameter bit MGMT_PRIO = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          h_wr,
   input  logic [ADDR_W-1:0]             h_addr,
   input  logic [7:0]                    h_wdata,
   input  logic                          m_wr,
   input  logic [ADDR_W-1:0]             m_addr,
   input  logic [7:0]                    m_wdata,
   output logic [NUM_BYTES*8-1:0]        data_flat,
   output logic [NUM_BYTES-1:0]          h_hit,
   output logic [NUM_BYTES-1:0]          m_hit
);
   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      assign h_hit[i] = h_wr && (h_addr == ADDR_W'(i));
      assign m_hit[i] = m_wr && (m_addr == ADDR_W'(i));

      logic [7:0] win_data;
      if (MGMT_PRIO) begin : g_mgmt_first
         assign win_data = m_hit[i] ? m_wdata : h_wdata;
      end else begin : g_host_first
         assign win_data = h_hit[i] ? h_wdata : m_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data_flat[i*8 +: 8] <= '0;
         else if (h_hit[i] || m_hit[i])
            data_flat[i*8 +: 8] <= win_data;
      end
   end
endmodule

// File: rtl/mbx_side_regs.sv
module mbx_side_regs #(
   parameter int NUM_BYTES = 16,
   parameter int ADDR_W    = 5,
   parameter int STAT_OFS  = 16,
   parameter int CTRL_OFS  = 19,
   parameter int EN_OFS    = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [7:0]           wdata,
   input  logic [NUM_BYTES-1:0] peer_hit,
   input  logic                 flag_set,
   output logic [NUM_BYTES-1:0] stat_q,
   output logic [NUM_BYTES-1:0] en_q,
   output logic                 flag_q,
   output logic                 mask_q,
   output logic                 ring,
   output logic                 irq
);
   import mbx_pkg::*;
   localparam int NBANK = NUM_BYTES / 8;

   logic [NUM_BYTES-1:0] stat_clr;
   logic                 ctrl_wr;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign stat_clr[b*8 +: 8] = (wr && addr == ADDR_W'(STAT_OFS + b)) ? wdata : 8'h00;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_q[b*8 +: 8] <= '0;
         else if (wr && addr == ADDR_W'(EN_OFS + b))
            en_q[b*8 +: 8] <= wdata;
      end
   end

   // A new event overrides a clear landing in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= '0;
      else
         stat_q <= (stat_q & ~stat_clr) | peer_hit;
   end

   assign ctrl_wr = wr && (addr == ADDR_W'(CTRL_OFS));
   assign ring    = ctrl_wr && wdata[CTRL_RING_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         flag_q <= flag_set | (flag_q & ~(ctrl_wr & wdata[CTRL_FLAG_BIT]));
         if (ctrl_wr)
            mask_q <= wdata[CTRL_MASK_BIT];
      end
   end

   assign irq = (|(stat_q & en_q)) | (flag_q & ~mask_q);
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
   parameter int NUM_BYTES = 16,
   parameter int ADDR_W    = 5,
   parameter int STAT_OFS  = 16,
   parameter int M_CTRL    = 18,
   parameter int H_CTRL    = 19,
   parameter int M_EN_OFS  = 20,
   parameter int H_EN_OFS  = 22
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [NUM_BYTES*8-1:0] data_flat,
   input  logic [NUM_BYTES-1:0]   stat,
   input  logic [NUM_BYTES-1:0]   m_en,
   input  logic [NUM_BYTES-1:0]   h_en,
   input  logic [7:0]             m_ctrl,
   input  logic [7:0]             h_ctrl,
   output logic [7:0]             rdata
);
   localparam int NBANK = NUM_BYTES / 8;
   localparam int IW    = $clog2(NUM_BYTES);

   logic [IW-1:0] idx;
   logic [7:0]    sel;

   assign idx = addr[IW-1:0];

   always_comb begin
      sel = '0;
      if (addr < ADDR_W'(NUM_BYTES))
         sel = data_flat[idx*8 +: 8];
      for (int b = 0; b < NBANK; b++) begin
         if (addr == ADDR_W'(STAT_OFS + b)) sel = stat[b*8 +: 8];
         if (addr == ADDR_W'(M_EN_OFS + b)) sel = m_en[b*8 +: 8];
         if (addr == ADDR_W'(H_EN_OFS + b)) sel = h_en[b*8 +: 8];
      end
      if (addr == ADDR_W'(M_CTRL)) sel = m_ctrl;
      if (addr == ADDR_W'(H_CTRL)) sel = h_ctrl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= sel;
   end
endmodule

// File: rtl/mbx_dual_irq.sv
module mbx_dual_irq #(
   parameter int NUM_BYTES = 16,
   parameter int ADDR_W    = 5,
   parameter bit MGMT_PRIO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [7:0]        h_wdata,
   output logic [7:0]        h_rdata,
   output logic              h_irq,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic              m_wr,
   input  logic              m_rd,
   input  logic [7:0]        m_wdata,
   output logic [7:0]        m_rdata,
   output logic              m_irq
);
   import mbx_pkg::*;

   localparam int NBANK    = NUM_BYTES / 8;
   localparam int STAT_OFS = NUM_BYTES;
   localparam int M_CTRL   = STAT_OFS + NBANK;
   localparam int H_CTRL   = M_CTRL + 1;
   localparam int M_EN_OFS = H_CTRL + 1;
   localparam int H_EN_OFS = M_EN_OFS + NBANK;
   localparam int MAP_SIZE = H_EN_OFS + NBANK;

   if (NUM_BYTES < 8 || (NUM_BYTES % 8) != 0) begin : g_bad_bytes
      $error("NUM_BYTES must be a non-zero multiple of 8");
   end
   if ((1 << ADDR_W) < MAP_SIZE) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_BYTES*8-1:0] data_flat;
   logic [NUM_BYTES-1:0]   h_hit, m_hit;
   logic [NUM_BYTES-1:0]   h_stat_q, h_en_q, m_stat_q, m_en_q;
   logic                   h_flag_q, h_mask_q, m_flag_q, m_mask_q;
   logic                   h_ring, m_ring;

   mbx_data_bank #(
      .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .MGMT_PRIO(MGMT_PRIO)
   ) u_data (
      .clk(clk), .rst_n(rst_n),
      .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
      .m_wr(m_wr), .m_addr(m_addr), .m_wdata(m_wdata),
      .data_flat(data_flat), .h_hit(h_hit), .m_hit(m_hit)
   );

   mbx_side_regs #(
      .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W),
      .STAT_OFS(STAT_OFS), .CTRL_OFS(H_CTRL), .EN_OFS(H_EN_OFS)
   ) u_host (
      .clk(clk), .rst_n(rst_n),
      .wr(h_wr), .addr(h_addr), .wdata(h_wdata),
      .peer_hit(m_hit), .flag_set((|m_hit) | m_ring),
      .stat_q(h_stat_q), .en_q(h_en_q), .flag_q(h_flag_q), .mask_q(h_mask_q),
      .ring(h_ring), .irq(h_irq)
   );

   mbx_side_regs #(
      .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W),
      .STAT_OFS(STAT_OFS), .CTRL_OFS(M_CTRL), .EN_OFS(M_EN_OFS)
   ) u_mgmt (
      .clk(clk), .rst_n(rst_n),
      .wr(m_wr), .addr(m_addr), .wdata(m_wdata),
      .peer_hit(h_hit), .flag_set(h_ring),
      .stat_q(m_stat_q), .en_q(m_en_q), .flag_q(m_flag_q), .mask_q(m_mask_q),
      .ring(m_ring), .irq(m_irq)
   );

   logic [7:0] h_ctrl_v, m_ctrl_v;
   assign h_ctrl_v = ctrl_view(h_flag_q, h_mask_q);
   assign m_ctrl_v = ctrl_view(m_flag_q, m_mask_q);

   mbx_rd_port #(
      .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS),
      .M_CTRL(M_CTRL), .H_CTRL(H_CTRL), .M_EN_OFS(M_EN_OFS), .H_EN_OFS(H_EN_OFS)
   ) u_h_rd (
      .clk(clk), .rst_n(rst_n), .rd(h_rd), .addr(h_addr),
      .data_flat(data_flat), .stat(h_stat_q), .m_en(m_en_q), .h_en(h_en_q),
      .m_ctrl(m_ctrl_v), .h_ctrl(h_ctrl_v), .rdata(h_rdata)
   );

   mbx_rd_port #(
      .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS),
      .M_CTRL(M_CTRL), .H_CTRL(H_CTRL), .M_EN_OFS(M_EN_OFS), .H_EN_OFS(H_EN_OFS)
   ) u_m_rd (
      .clk(clk), .rst_n(rst_n), .rd(m_rd), .addr(m_addr),
      .data_flat(data_flat), .stat(m_stat_q), .m_en(m_en_q), .h_en(h_en_q),
      .m_ctrl(m_ctrl_v), .h_ctrl(h_ctrl_v), .rdata(m_rdata)
   );
endmodule

// File: rtl/mbx_dual_irq_chk.sv
module mbx_dual_irq_chk #(
   parameter int NUM_BYTES = 16,
   parameter int ADDR_W    = 5,
   parameter int H_CTRL    = 19
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    h_addr,
   input logic                 h_wr,
   input logic                 h_rd,
   input logic [7:0]           h_wdata,
   input logic [7:0]           h_rdata,
   input logic                 h_irq,
   input logic [ADDR_W-1:0]    m_addr,
   input logic                 m_wr,
   input logic [NUM_BYTES-1:0] h_stat_q,
   input logic [NUM_BYTES-1:0] h_en_q,
   input logic                 h_flag_q,
   input logic                 h_mask_q,
   input logic                 m_flag_q
);
   localparam int IW = $clog2(NUM_BYTES);

   logic          m_data_wr;
   logic [IW-1:0] last_idx;

   assign m_data_wr = m_wr && (m_addr < ADDR_W'(NUM_BYTES));

   always_ff @(posedge clk) last_idx <= m_addr[IW-1:0];

   AST_MWR_SETS_HSTAT: assert property (@(posedge clk) disable iff (!rst_n)
      m_data_wr |=> h_stat_q[last_idx]); // R3

   AST_NO_SPURIOUS_HSTAT: assert property (@(posedge clk) disable iff (!rst_n)
      !m_data_wr |=> ((h_stat_q & ~$past(h_stat_q)) == '0)); // R3

   AST_MWR_RAISES_HFLAG: assert property (@(posedge clk) disable iff (!rst_n)
      m_data_wr |=> h_flag_q); // R7

   AST_MASK_BLOCKS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (h_mask_q && ((h_stat_q & h_en_q) == '0)) |-> !h_irq); // R7

   AST_RING_TO_MGMT: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_addr == ADDR_W'(H_CTRL) && h_wdata[0]) |=> m_flag_q); // R8

   AST_RING_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rd && h_addr == ADDR_W'(H_CTRL)) |=> !h_rdata[0]); // R8
endmodule

bind mbx_dual_irq mbx_dual_irq_chk #(
   .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .H_CTRL(H_CTRL)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
   .h_rdata(h_rdata), .h_irq(h_irq),
   .m_addr(m_addr), .m_wr(m_wr),
   .h_stat_q(h_stat_q), .h_en_q(h_en_q), .h_flag_q(h_flag_q),
   .h_mask_q(h_mask_q), .m_flag_q(m_flag_q)
);

// File: tb/mbx_dual_irq_bench.sv
module mbx_dual_irq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] h_addr = '0, m_addr = '0;
   logic       h_wr = 1'b0, h_rd = 1'b0, m_wr = 1'b0, m_rd = 1'b0;
   logic [7:0] h_wdata = '0, m_wdata = '0;
   logic [7:0] h_rdata, m_rdata;
   logic       h_irq, m_irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   mbx_dual_irq u_mbx_dual_irq (
      .clk(clk), .rst_n(rst_n),
      .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
      .h_rdata(h_rdata), .h_irq(h_irq),
      .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata),
      .m_rdata(m_rdata), .m_irq(m_irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic hw(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
      @(negedge clk); h_wr = 1'b0;
   endtask

   task automatic mw(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); m_addr = a; m_wdata = d; m_wr = 1'b1;
      @(negedge clk); m_wr = 1'b0;
   endtask

   task automatic both(input logic [4:0] ha, input logic [7:0] hd,
                       input logic [4:0] ma, input logic [7:0] md);
      @(negedge clk);
      h_addr = ha; h_wdata = hd; h_wr = 1'b1;
      m_addr = ma; m_wdata = md; m_wr = 1'b1;
      @(negedge clk); h_wr = 1'b0; m_wr = 1'b0;
   endtask

   task automatic hr(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk); h_addr = a; h_rd = 1'b1;
      @(negedge clk); h_rd = 1'b0; d = h_rdata;
   endtask

   task automatic mr(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk); m_addr = a; m_rd = 1'b1;
      @(negedge clk); m_rd = 1'b0; d = m_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 h_irq", {7'b0, h_irq}, 8'h00);
      chk("R1 m_irq", {7'b0, m_irq}, 8'h00);
      hr(5'h00, v); chk("R1 data0", v, 8'h00);
      hr(5'h10, v); chk("R1 status", v, 8'h00);
      hr(5'h13, v); chk("R1 host ctrl", v, 8'h00);
      mr(5'h12, v); chk("R1 mgmt ctrl", v, 8'h00);
      mr(5'h16, v); chk("R1 host enable", v, 8'h00);
   endtask

   task automatic t_data();
      logic [7:0] v;
      hw(5'h03, 8'hA5);
      mr(5'h03, v); chk("R2 mgmt reads host byte", v, 8'hA5);
      mr(5'h10, v); chk("R3 mgmt status bit3", v, 8'h08);
      chk("R6 m_irq no enable", {7'b0, m_irq}, 8'h00);
      mw(5'h10, 8'h08);
      mr(5'h10, v); chk("R4 mgmt status cleared", v, 8'h00);
      mw(5'h0C, 8'h3C);
      hr(5'h0C, v); chk("R2 host reads mgmt byte", v, 8'h3C);
   endtask

   task automatic t_status();
      logic [7:0] v;
      hr(5'h11, v); chk("R3 host status byte12", v, 8'h10);
      chk("R7 flag drives h_irq", {7'b0, h_irq}, 8'h01);
      hw(5'h13, 8'h80);
      chk("R7 flag cleared", {7'b0, h_irq}, 8'h00);
      hw(5'h11, 8'h00);
      hr(5'h11, v); chk("R4 zero write keeps", v, 8'h10);
      hw(5'h11, 8'h10);
      hr(5'h11, v); chk("R4 one write clears", v, 8'h00);
   endtask

   task automatic t_enable();
      logic [7:0] v;
      hw(5'h17, 8'h80);
      hw(5'h13, 8'h02);
      mw(5'h0F, 8'h11);
      chk("R6 enabled byte15 irq", {7'b0, h_irq}, 8'h01);
      hr(5'h11, v); chk("R3 byte15 bit7", v, 8'h80);
      mw(5'h0E, 8'h22);
      hw(5'h11, 8'h80);
      chk("R7 masked flag, R6 disabled bit", {7'b0, h_irq}, 8'h00);
      hr(5'h11, v); chk("R4 bit6 left", v, 8'h40);
      hw(5'h11, 8'h40);
      hw(5'h13, 8'h82);
      hr(5'h13, v); chk("R7 mask kept, flag cleared", v, 8'h02);
      hw(5'h13, 8'h00);
      hw(5'h17, 8'h00);
      mw(5'h14, 8'h01);
      hw(5'h00, 8'h77);
      chk("R6 mgmt enable irq", {7'b0, m_irq}, 8'h01);
      chk("R6 host unaffected", {7'b0, h_irq}, 8'h00);
      mw(5'h10, 8'h01);
      chk("R6 mgmt irq drops", {7'b0, m_irq}, 8'h00);
      mw(5'h14, 8'h00);
   endtask

   task automatic t_set_wins();
      logic [7:0] v;
      mw(5'h02, 8'h01);
      both(5'h10, 8'h04, 5'h02, 8'h02);
      hr(5'h10, v); chk("R5 status set beats clear", v, 8'h04);
      both(5'h13, 8'h80, 5'h02, 8'h03);
      chk("R5 flag set beats clear", {7'b0, h_irq}, 8'h01);
      hw(5'h10, 8'h04);
      hw(5'h13, 8'h80);
      chk("R5 cleanup irq", {7'b0, h_irq}, 8'h00);
   endtask

   task automatic t_ring();
      logic [7:0] v;
      hw(5'h13, 8'h01);
      chk("R8 doorbell m_irq", {7'b0, m_irq}, 8'h01);
      mr(5'h12, v); chk("R8 mgmt flag", v, 8'h80);
      hr(5'h13, v); chk("R8 doorbell reads 0", v, 8'h00);
      mw(5'h12, 8'h80);
      chk("R8 mgmt clear", {7'b0, m_irq}, 8'h00);
      hw(5'h13, 8'h03);
      chk("R8 combined ring", {7'b0, m_irq}, 8'h01);
      hr(5'h13, v); chk("R8 combined mask", v, 8'h02);
      mw(5'h12, 8'h80);
      mw(5'h12, 8'h01);
      hr(5'h13, v); chk("R8 mgmt doorbell to host", v, 8'h82);
      chk("R8 masked host flag", {7'b0, h_irq}, 8'h00);
      hw(5'h13, 8'h80);
   endtask

   task automatic t_isolation();
      logic [7:0] v;
      hw(5'h12, 8'hFF);
      mr(5'h12, v); chk("R9 host to mgmt ctrl", v, 8'h00);
      chk("R9 m_irq quiet", {7'b0, m_irq}, 8'h00);
      hw(5'h14, 8'hFF);
      hr(5'h14, v); chk("R9 host to mgmt enable", v, 8'h00);
      mw(5'h16, 8'hFF);
      hr(5'h16, v); chk("R9 mgmt to host enable", v, 8'h00);
      mw(5'h13, 8'h81);
      hr(5'h13, v); chk("R9 mgmt to host ctrl", v, 8'h00);
      chk("R9 h_irq quiet", {7'b0, h_irq}, 8'h00);
   endtask

   task automatic t_collision();
      logic [7:0] v;
      both(5'h05, 8'h11, 5'h05, 8'h22);
      hr(5'h05, v); chk("R2 mgmt wins collision", v, 8'h22);
      hr(5'h10, v); chk("R3 host status on collision", v, 8'h20);
      mr(5'h10, v); chk("R3 mgmt status on collision", v, 8'h20);
      hw(5'h10, 8'h20); hw(5'h13, 8'h80); mw(5'h10, 8'h20);
   endtask

   task automatic t_read_hold();
      logic [7:0] v;
      hr(5'h03, v); chk("R10 read", v, 8'hA5);
      @(negedge clk); h_addr = 5'h0C;
      @(negedge clk); chk("R10 hold without strobe", h_rdata, 8'hA5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data();
      t_status();
      t_enable();
      t_set_wins();
      t_ring();
      t_isolation();
      t_collision();
      t_read_hold();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule